// File: doc/BRIEF.md
# Four-Lane Byte-Enabled Static Memory

This block is a synthesizable model of a 32-bit static memory made of four independent 8-bit lanes. All lanes see one shared address bus and one shared active-low output enable. Each lane has its own active-low chip enable and active-low write enable, so the pattern of enables picks any mix of 8-, 16-, 24- or 32-bit reads and writes. The bidirectional data bus is split into an input half, an output half and a per-lane drive-enable. A bench or a pad ring can therefore check bus ownership without real tri-state drivers. Each lane also raises a clash flag when an outside driver and the lane drive it at the same time.

Each lane is run by a small state machine with four states. `ST_STANDBY` means the chip enable is high. `ST_IDLE` means the lane is enabled but neither reading nor writing. `ST_READ` means the lane is enabled and driving. `ST_WRITE` means the write strobe is active. Every clock the next state is decoded from the lane's controls. The named transitions are: select (STANDBY to IDLE/READ/WRITE), deselect (any state to STANDBY), output-on (IDLE to READ), output-off (READ to IDLE), write-start (any state to WRITE) and write-end (WRITE to any other state). Write-end commits the held byte to storage. Read data and drive-enables follow the controls combinationally. Storage depth is a parameter, and only the low address bits are decoded.

Top module: `quad_lane_sram`

## Requirements
- R1: Lane i (0..3) owns data bits [8i+7:8i] of `dq_in`, `dq_out` and bit i of `dq_oe` and `bus_clash`. All lanes share `addr` and `oe_n`.
- R2: `ce_n`, `we_n` and `oe_n` are active low: 0 means asserted.
- R3: While a lane's `ce_n` bit is 1, the lane neither drives (`dq_oe` bit 0) nor writes, whatever its `we_n` bit and `oe_n` are.
- R4: A lane with `ce_n` and `we_n` both 0 is writing. It does not drive, and the value of `oe_n` has no effect on the write.
- R5: A lane drives (`dq_oe` bit 1) exactly when its `ce_n` is 0, its `we_n` is 1 and `oe_n` is 0. Its `dq_out` byte is then the byte stored at the current address, with no clock delay.
- R6: A lane with `ce_n` 0, `we_n` 1 and `oe_n` 1 is active but does not drive.
- R7: A write ends at the first clock edge where either `we_n` or `ce_n` of that lane is seen high. The stored byte and address are those present at the last edge where both were low. The new value is readable from the edge that ends the write.
- R8: A write touches only the lanes whose strobes were active. The other lanes keep their bytes at that address.
- R9: `bus_clash` bit i is 1 exactly when `dq_ext_en` bit i and `dq_oe` bit i are both 1.
- R10: Reset (`rst_n` 0) puts every lane in standby with no pending write. A write strobe active during reset is discarded and stores nothing.
- R11: Only address bits [AW-1:0], with AW = log2(DEPTH), select a location. Addresses differing only in higher bits alias to the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the write strobes |
| rst_n | input | 1 | Active-low reset |
| addr | input | 19 | Shared word address |
| ce_n | input | 4 | Per-lane active-low chip enable |
| we_n | input | 4 | Per-lane active-low write enable |
| oe_n | input | 1 | Shared active-low output enable |
| dq_in | input | 32 | Data arriving on the bus from outside |
| dq_ext_en | input | 4 | Per-lane flag: an outside driver is on the bus |
| dq_out | output | 32 | Data the lanes drive (zero where not driving) |
| dq_oe | output | 4 | Per-lane drive-enable |
| bus_clash | output | 4 | Per-lane contention flag |

## Verification
The hardest case to reach is a write ended by the chip enable while the write enable is still low. The data changes during the strobe, so the stored byte must be the last value before the strobe ends. The bench forces this with a three-cycle strobe in which the data changes between cycles, and it lifts `ce_n` before `we_n`. A strobe held across reset is also checked to prove it is discarded. A full sweep of every per-lane enable combination against the output enable shows that the output-enable level never alters the written bytes.

// File: rtl/quad_lane_sram_pkg.sv
package quad_lane_sram_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 19;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } lane_state_t;

endpackage

// File: rtl/sram_lane_store.sv
module sram_lane_store
    import quad_lane_sram_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // a committed byte is found at its location one edge later
    assert_commit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import quad_lane_sram_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr_lo,
    input  logic [BYTE_W-1:0] din,
    input  logic              ext_en,
    output logic              drive_en,
    output logic              clash,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    lane_state_t state_q, state_d;
    logic        strobe;
    logic [AW-1:0]     hold_addr;
    logic [BYTE_W-1:0] hold_data;

    assign strobe = !ce_n && !we_n;

    // next-state decode from the lane's controls
    always_comb begin
        if (ce_n)          state_d = ST_STANDBY;
        else if (!we_n)    state_d = ST_WRITE;
        else if (!oe_n)    state_d = ST_READ;
        else               state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    // write holding register: last address and byte seen under the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else if (strobe) begin
            hold_addr <= addr_lo;
            hold_data <= din;
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            ST_STANDBY: wr_en = 1'b0;
            ST_IDLE:    wr_en = 1'b0;
            ST_READ:    wr_en = 1'b0;
            ST_WRITE:   wr_en = (state_d != ST_WRITE);
            default:    wr_en = 1'b0;
        endcase
        drive_en = (state_d == ST_READ);
    end

    assign wr_addr = hold_addr;
    assign wr_data = hold_data;
    assign clash   = drive_en && ext_en;

    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (state_q == ST_STANDBY));

    assert_write_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (state_q == ST_WRITE));

    assert_no_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && !ce_n && !we_n) |-> !drive_en);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $stable(ce_n) && $stable(we_n) && $stable(oe_n)) |-> !drive_en);

    assert_write_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && (ce_n || we_n)) |-> wr_en);

    assert_no_stray_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WRITE) |-> !wr_en);

endmodule

// File: rtl/quad_lane_sram.sv
module quad_lane_sram
    import quad_lane_sram_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  ce_n,
    input  logic [LANES-1:0]  we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [LANES-1:0]  dq_ext_en,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic [LANES-1:0]  bus_clash
);

    logic [AW-1:0]            addr_lo;
    logic [ADDR_W-AW-1:0]     addr_hi_unused;

    assign addr_lo        = addr[AW-1:0];
    assign addr_hi_unused = addr[ADDR_W-1:AW];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic              drive;
        logic              wr_en;
        logic [AW-1:0]     wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic [BYTE_W-1:0] rd_data;

        sram_lane_ctrl #(.DEPTH(DEPTH)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .ce_n     (ce_n[g]),
            .we_n     (we_n[g]),
            .oe_n     (oe_n),
            .addr_lo  (addr_lo),
            .din      (dq_in[g*BYTE_W +: BYTE_W]),
            .ext_en   (dq_ext_en[g]),
            .drive_en (drive),
            .clash    (bus_clash[g]),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data)
        );

        sram_lane_store #(.DEPTH(DEPTH)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (addr_lo),
            .rd_data (rd_data)
        );

        assign dq_oe[g]                   = drive;
        assign dq_out[g*BYTE_W +: BYTE_W] = drive ? rd_data : '0;

        assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
            bus_clash[g] |-> (dq_ext_en[g] && dq_oe[g]));

        assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !dq_oe[g] |-> (dq_out[g*BYTE_W +: BYTE_W] == '0));
    end

endmodule

// File: tb/sim_quad_lane_sram.sv
`timescale 1ns/1ps
module sim_quad_lane_sram;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic [3:0]  ce_n = 4'hF;
    logic [3:0]  we_n = 4'hF;
    logic        oe_n = 1'b1;
    logic [31:0] dq_in = '0;
    logic [3:0]  dq_ext_en = '0;
    logic [31:0] dq_out;
    logic [3:0]  dq_oe;
    logic [3:0]  bus_clash;

    int total = 0;
    int bad = 0;
    logic [31:0] mdl [DEPTH];

    always #10 clk = ~clk;

    quad_lane_sram #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .dq_in(dq_in), .dq_ext_en(dq_ext_en),
        .dq_out(dq_out), .dq_oe(dq_oe), .bus_clash(bus_clash)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 4'hF; we_n = 4'hF; oe_n = 1'b1; dq_ext_en = '0;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = d[l*8 +: 8];
        return r;
    endfunction

    // strobe one cycle, change data as the strobe ends (R7: the change is not stored)
    task automatic write_word(input logic [18:0] a, input logic [3:0] m, input logic [31:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = ~m; we_n = ~m; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 4'hF; we_n = 4'hF; dq_in = ~d;
    endtask

    task automatic read_chk(input string tag, input logic [18:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a; ce_n = 4'h0; we_n = 4'hF; oe_n = 1'b0;
        #2;
        chk(tag, dq_out, exp);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state, and a strobe held across reset stores nothing
        @(negedge clk);
        addr = 19'd2; dq_in = 32'hDEAD_BEEF; ce_n = 4'h0; we_n = 4'h0;
        @(negedge clk);
        chk("R10 no drive in reset", {28'd0, dq_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ce_n = 4'hF; we_n = 4'hF;
        #2;
        chk("R10 reset drive", {28'd0, dq_oe}, 32'd0);

        // R1 R2 R5: full-word writes to every location, then read back
        for (int a = 0; a < DEPTH; a++) begin
            mdl[a] = (a * 32'h0101_0101) ^ 32'h5A3C_96E1;
            write_word(19'(a), 4'hF, mdl[a]);
        end
        idle();
        for (int a = 0; a < DEPTH; a++) read_chk("R5 R1 word readback", 19'(a), mdl[a]);

        // R8: every byte-lane mask
        for (int m = 1; m < 16; m++) begin
            logic [31:0] d = ~(m * 32'h1357_9BDF);
            mdl[m] = merge(mdl[m], d, 4'(m));
            write_word(19'(m), 4'(m), d);
        end
        idle();
        for (int a = 0; a < DEPTH; a++) read_chk("R8 lane mask readback", 19'(a), mdl[a]);

        // R3 R4 R5 R6 R9: sweep per-lane ce/we with oe and an outside-driver pattern
        for (int c = 0; c < 512; c++) begin
            logic [3:0] ce = c[3:0];
            logic [3:0] we = c[7:4];
            logic       oe = c[8];
            logic [3:0] exp_oe = (~ce) & we & {4{~oe}};
            logic [3:0] ext = c[3:0] ^ c[7:4] ^ {4{c[8]}} ^ 4'h6;
            logic [31:0] d = c * 32'h0B1D_2E35;
            @(negedge clk);
            addr = 19'd5; dq_in = d; ce_n = ce; we_n = we; oe_n = oe; dq_ext_en = ext;
            #2;
            chk("R3 R4 R5 R6 drive enable", {28'd0, dq_oe}, {28'd0, exp_oe});
            chk("R9 clash", {28'd0, bus_clash}, {28'd0, exp_oe & ext});
            mdl[5] = merge(mdl[5], d, (~ce) & (~we));
            idle();
        end
        idle();
        read_chk("R4 oe ignored in write, sweep result", 19'd5, mdl[5]);

        // R7: write ended by ce_n while we_n still low; data changes inside strobe
        @(negedge clk);
        addr = 19'd9; ce_n = 4'h0; we_n = 4'h0; dq_in = 32'h1111_1111;
        @(negedge clk);
        dq_in = 32'h2222_2222;
        @(negedge clk);
        ce_n = 4'hF; dq_in = 32'h3333_3333;
        @(negedge clk);
        we_n = 4'hF;
        mdl[9] = 32'h2222_2222;
        read_chk("R7 ce-ended write keeps last strobed data", 19'd9, mdl[9]);

        // R7: readable right after the ending edge
        @(negedge clk);
        addr = 19'd10; ce_n = 4'h0; we_n = 4'h0; dq_in = 32'hCAFE_F00D;
        @(negedge clk);
        we_n = 4'hF; oe_n = 1'b0; dq_in = 32'h0;
        #2;
        chk("R7 before end edge old data", dq_out, mdl[10]);
        @(negedge clk);
        #2;
        mdl[10] = 32'hCAFE_F00D;
        chk("R7 after end edge new data", dq_out, mdl[10]);

        // R11: high address bits alias
        idle();
        mdl[3] = 32'h0F1E_2D3C;
        write_word(19'h7FFF0 | 19'd3, 4'hF, mdl[3]);
        idle();
        read_chk("R11 alias read low", 19'd3, mdl[3]);
        read_chk("R11 alias read high", 19'h40013, mdl[3]);

        // R10: reset while a strobe is pending discards it
        @(negedge clk);
        addr = 19'd4; ce_n = 4'h0; we_n = 4'h0; dq_in = 32'hBADB_AD00;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        ce_n = 4'hF; we_n = 4'hF;
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        read_chk("R10 strobe across reset discarded", 19'd4, mdl[4]);

        idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule